// File: doc/BRIEF.md
# Display Register Read Engine with One-Bit Realignment

This block is an SPI master that fetches identification and status words from a display controller. The controller answers a register read with one dummy clock before the real data, so every byte it returns arrives one bit late. The engine sends the 8-bit register code with the data/command line low. It then clocks in five bytes with MOSI held low and rebuilds the aligned 32-bit word from the 40 bits it received. It ends the access by pulsing chip select high, which cancels the frame the slave has only partly received.

A second mode reads an extended register one parameter at a time. For each parameter index from 1 to 3 it sends a read-enable command, then a data byte naming the parameter, then the register code, then it clocks in one byte. Parameter 0 is a dummy and is never fetched. The read-enable code comes from a configuration input, so one engine serves controllers that use different codes. A request is a single-cycle strobe. `busy` covers the whole access and `done` marks the cycle in which `result` becomes valid.

Top module: `dispreg_rd_engine`

## Requirements
- R1: After reset: `spi_cs_n`=1, `spi_sck`=0, `spi_mosi`=0, `spi_dc`=1, `busy`=0, `done`=0, `result`=0.
- R2: The SPI bus runs in mode 0, MSB first. SCK idles low. MOSI changes only while SCK is low. MISO is sampled on the rising edge of SCK. Each SCK half period lasts HALF_DIV clocks. `spi_sck` is high only while `spi_cs_n` is low.
- R3: In normal mode (`req_ext`=0) the byte sequence is the register code with `spi_dc`=0, followed by five receive bytes with `spi_dc`=1 and `spi_mosi` held low.
- R4: Number the 40 received bits 39 (the first) down to 0 (the last). In normal mode `result` is bits 38..7. Bit 39 is the dummy cycle and bits 6..0 are discarded.
- R5: An access ends with `spi_cs_n` high for exactly CS_PULSE clocks. It then returns low and stays low until the next access.
- R6: `done` is a one-cycle pulse. It rises on the same edge on which `spi_cs_n` returns low and `busy` falls. `result` holds its value from one `done` to the next.
- R7: `req_valid` is ignored while `busy` is high. Such a strobe starts no access and does not alter the access in progress.
- R8: In extended mode (`req_ext`=1), for p = 1, 2, 3 in that order the engine sends four bytes. These are the read-enable code (`spi_dc`=0), the data byte 0xF0|p (`spi_dc`=1), the register code (`spi_dc`=0) and one receive byte (`spi_dc`=1, MOSI low). No dummy bit is skipped, and `result` = {8'h00, byte(p=1), byte(p=2), byte(p=3)}.
- R9: The read-enable code is captured from `cfg_unlock` when a request is accepted, for example 0xD9 or 0xFB.
- R10: `done` rises N*(16*HALF_DIV+2)+CS_PULSE clock edges after the edge that accepts the request. N is 6 in normal mode and 12 in extended mode.
- R11: `busy` is high from the edge that accepts a request until the edge that raises `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken when not busy |
| req_ext | input | 1 | 1 selects extended-register mode |
| req_addr | input | 8 | Register code to read |
| cfg_unlock | input | 8 | Read-enable command code for extended mode |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle pulse, result valid |
| result | output | 32 | Reassembled register value |
| spi_sck | output | 1 | SPI clock, idles low |
| spi_mosi | output | 1 | Serial data to the controller |
| spi_miso | input | 1 | Serial data from the controller |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_dc | output | 1 | Data/command select, 0 = command |

## Verification
`done` is due exactly N*(16*HALF_DIV+2)+CS_PULSE edges after the accepting edge. The bench counts edges from the request and compares the count in the cycle where `done` is first seen. It samples every output at the falling clock edge, so registered values have settled. The controller model shifts MISO on each SCK fall and logs every byte with its data/command level on the eighth SCK rise. The bench compares those logs, the high time of chip select and `result` against values it derives from the stimulus alone.

// File: rtl/dispreg_rd_pkg.sv
package dispreg_rd_pkg;

    localparam int BYTE_W      = 8;
    localparam int WORD_W      = 32;
    localparam int NORM_STEPS  = 6;   // command + five receive bytes
    localparam int EXT_PARAMS  = 3;
    localparam int EXT_STEPS   = 4 * EXT_PARAMS;
    localparam int ACC_W       = 5 * BYTE_W;
    localparam int IDX_W       = $clog2(EXT_STEPS);
    localparam logic [3:0] PARAM_TAG = 4'hF;

    typedef enum logic [1:0] {
        STEP_CMD,
        STEP_DAT,
        STEP_RX
    } step_kind_e;

    typedef struct packed {
        step_kind_e        kind;
        logic [BYTE_W-1:0] tx;
        logic              last;
    } step_t;

    typedef enum logic [1:0] {
        EN_IDLE,
        EN_ISSUE,
        EN_WAIT,
        EN_CSHI
    } eng_state_e;

    // Byte schedule of one access, indexed by step number.
    function automatic step_t step_at(input logic ext,
                                      input logic [IDX_W-1:0] idx,
                                      input logic [BYTE_W-1:0] reg_code,
                                      input logic [BYTE_W-1:0] en_code);
        step_t      s;
        logic [3:0] p;
        s.kind = STEP_RX;
        s.tx   = '0;
        s.last = 1'b0;
        p      = {2'b00, idx[3:2]} + 4'd1;
        if (!ext) begin
            if (idx == '0) begin
                s.kind = STEP_CMD;
                s.tx   = reg_code;
            end
            s.last = (idx == IDX_W'(NORM_STEPS - 1));
        end else begin
            unique case (idx[1:0])
                2'd0: begin s.kind = STEP_CMD; s.tx = en_code;         end
                2'd1: begin s.kind = STEP_DAT; s.tx = {PARAM_TAG, p};  end
                2'd2: begin s.kind = STEP_CMD; s.tx = reg_code;        end
                default: begin s.kind = STEP_RX; s.tx = '0;            end
            endcase
            s.last = (idx == IDX_W'(EXT_STEPS - 1));
        end
        return s;
    endfunction

    // Pick the answer out of the receive accumulator.
    function automatic logic [WORD_W-1:0] realign(input logic ext,
                                                  input logic [ACC_W-1:0] acc);
        if (ext)
            return {8'h00, acc[3*BYTE_W-1:0]};
        return acc[ACC_W-2 -: WORD_W];
    endfunction

endpackage

// File: rtl/dispreg_spi_shifter.sv
module dispreg_spi_shifter #(
    parameter int HALF_DIV = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic [7:0] tx_byte,
    input  logic       miso,
    output logic       sck,
    output logic       mosi,
    output logic [7:0] rx_byte,
    output logic       byte_done
);
    localparam int DIV_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

    logic             active;
    logic [DIV_W-1:0] div_cnt;
    logic [2:0]       bit_cnt;
    logic [7:0]       tx_sh;
    logic [7:0]       rx_sh;

    always_ff @(posedge clk) begin
        if (rst) begin
            active    <= 1'b0;
            div_cnt   <= '0;
            bit_cnt   <= '0;
            tx_sh     <= '0;
            rx_sh     <= '0;
            sck       <= 1'b0;
            byte_done <= 1'b0;
        end else begin
            byte_done <= 1'b0;
            if (!active) begin
                if (start) begin
                    active  <= 1'b1;
                    tx_sh   <= tx_byte;
                    div_cnt <= '0;
                    bit_cnt <= '0;
                    sck     <= 1'b0;
                end
            end else if (div_cnt == DIV_W'(HALF_DIV - 1)) begin
                div_cnt <= '0;
                if (!sck) begin
                    sck   <= 1'b1;
                    rx_sh <= {rx_sh[6:0], miso};
                end else begin
                    sck   <= 1'b0;
                    tx_sh <= {tx_sh[6:0], 1'b0};
                    if (bit_cnt == 3'd7) begin
                        active    <= 1'b0;
                        byte_done <= 1'b1;
                    end else begin
                        bit_cnt <= bit_cnt + 3'd1;
                    end
                end
            end else begin
                div_cnt <= div_cnt + DIV_W'(1);
            end
        end
    end

    assign mosi    = active & tx_sh[7];
    assign rx_byte = rx_sh;

endmodule

// File: rtl/dispreg_collect.sv
module dispreg_collect
    import dispreg_rd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              shift_en,
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic              ext,
    output logic [WORD_W-1:0] value
);
    logic [ACC_W-1:0] acc;

    always_ff @(posedge clk) begin
        if (rst || clr)
            acc <= '0;
        else if (shift_en)
            acc <= {acc[ACC_W-BYTE_W-1:0], rx_byte};
    end

    assign value = realign(ext, acc);

endmodule

// File: rtl/dispreg_rd_engine.sv
module dispreg_rd_engine
    import dispreg_rd_pkg::*;
#(
    parameter int HALF_DIV = 2,
    parameter int CS_PULSE = 3
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    input  logic        req_ext,
    input  logic [7:0]  req_addr,
    input  logic [7:0]  cfg_unlock,
    output logic        busy,
    output logic        done,
    output logic [31:0] result,
    output logic        spi_sck,
    output logic        spi_mosi,
    input  logic        spi_miso,
    output logic        spi_cs_n,
    output logic        spi_dc
);
    localparam int PC_W = (CS_PULSE > 1) ? $clog2(CS_PULSE) : 1;

    eng_state_e        state;
    logic [IDX_W-1:0]  idx;
    logic [PC_W-1:0]   pcnt;
    logic              mode_ext;
    logic [BYTE_W-1:0] addr_q;
    logic [BYTE_W-1:0] unlock_q;
    step_t             cur;

    logic              sh_start;
    logic [BYTE_W-1:0] sh_rx;
    logic              sh_done;
    logic              acc_clr;
    logic              acc_shift;
    logic [WORD_W-1:0] acc_value;

    assign cur       = step_at(mode_ext, idx, addr_q, unlock_q);
    assign sh_start  = (state == EN_ISSUE);
    assign acc_clr   = (state == EN_IDLE) && req_valid;
    assign acc_shift = (state == EN_WAIT) && sh_done && (cur.kind == STEP_RX);
    assign busy      = (state != EN_IDLE);

    dispreg_spi_shifter #(.HALF_DIV(HALF_DIV)) u_shift (
        .clk      (clk),
        .rst      (rst),
        .start    (sh_start),
        .tx_byte  (cur.tx),
        .miso     (spi_miso),
        .sck      (spi_sck),
        .mosi     (spi_mosi),
        .rx_byte  (sh_rx),
        .byte_done(sh_done)
    );

    dispreg_collect u_coll (
        .clk     (clk),
        .rst     (rst),
        .clr     (acc_clr),
        .shift_en(acc_shift),
        .rx_byte (sh_rx),
        .ext     (mode_ext),
        .value   (acc_value)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= EN_IDLE;
            idx      <= '0;
            pcnt     <= '0;
            mode_ext <= 1'b0;
            addr_q   <= '0;
            unlock_q <= '0;
            spi_cs_n <= 1'b1;
            spi_dc   <= 1'b1;
            done     <= 1'b0;
            result   <= '0;
        end else begin
            done <= 1'b0;
            unique case (state)
                EN_IDLE: begin
                    if (req_valid) begin
                        mode_ext <= req_ext;
                        addr_q   <= req_addr;
                        unlock_q <= cfg_unlock;
                        idx      <= '0;
                        spi_cs_n <= 1'b0;
                        state    <= EN_ISSUE;
                    end
                end
                EN_ISSUE: begin
                    spi_dc <= (cur.kind != STEP_CMD);
                    state  <= EN_WAIT;
                end
                EN_WAIT: begin
                    if (sh_done) begin
                        if (cur.last) begin
                            spi_cs_n <= 1'b1;
                            spi_dc   <= 1'b1;
                            pcnt     <= '0;
                            state    <= EN_CSHI;
                        end else begin
                            idx   <= idx + IDX_W'(1);
                            state <= EN_ISSUE;
                        end
                    end
                end
                default: begin
                    if (pcnt == PC_W'(CS_PULSE - 1)) begin
                        spi_cs_n <= 1'b0;
                        done     <= 1'b1;
                        result   <= acc_value;
                        state    <= EN_IDLE;
                    end else begin
                        pcnt <= pcnt + PC_W'(1);
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/dispreg_rd_checker.sv
module dispreg_rd_checker (
    input logic        clk,
    input logic        rst,
    input logic        busy,
    input logic        done,
    input logic [31:0] result,
    input logic        spi_sck,
    input logic        spi_mosi,
    input logic        spi_cs_n,
    input logic        spi_dc
);
    AST_SCK_NEEDS_SELECT: assert property (@(posedge clk) disable iff (rst)
        spi_sck |-> !spi_cs_n);                                   // R2
    AST_IDLE_BUS_QUIET: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!spi_sck && !spi_mosi && spi_dc));             // R3
    AST_DONE_AFTER_CS_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |-> ($past(spi_cs_n) && !spi_cs_n));                 // R5
    AST_DONE_CLEARS_BUSY: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);                                          // R6
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);                                          // R6
    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (rst)
        busy |-> $stable(result));                                // R6
endmodule

bind dispreg_rd_engine dispreg_rd_checker u_chk (
    .clk     (clk),
    .rst     (rst),
    .busy    (busy),
    .done    (done),
    .result  (result),
    .spi_sck (spi_sck),
    .spi_mosi(spi_mosi),
    .spi_cs_n(spi_cs_n),
    .spi_dc  (spi_dc)
);

// File: tb/dispreg_rd_engine_bench.sv
`timescale 1ns/1ps
module dispreg_rd_engine_bench;
    localparam int HALF_DIV = 2;
    localparam int CS_PULSE = 3;
    localparam int BYTE_CYC = 16 * HALF_DIV + 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ext = 1'b0;
    logic [7:0]  req_addr = '0;
    logic [7:0]  cfg_unlock = '0;
    logic        busy, done, spi_sck, spi_mosi, spi_cs_n, spi_dc;
    logic [31:0] result;
    logic        spi_miso = 1'b0;

    int checks = 0;
    int failures = 0;

    always #2 clk = ~clk;

    dispreg_rd_engine #(.HALF_DIV(HALF_DIV), .CS_PULSE(CS_PULSE)) u_dispreg_rd_engine (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ext(req_ext),
        .req_addr(req_addr), .cfg_unlock(cfg_unlock), .busy(busy), .done(done),
        .result(result), .spi_sck(spi_sck), .spi_mosi(spi_mosi),
        .spi_miso(spi_miso), .spi_cs_n(spi_cs_n), .spi_dc(spi_dc)
    );

    // Controller model: logs each byte with its D/C level, answers reads.
    logic [8:0]  slog [0:255];
    int          slog_n = 0;
    int          bc = 0;
    logic [7:0]  sh = '0;
    logic [39:0] resp = '0;
    logic        en_seen = 1'b0;
    logic [1:0]  ext_p = '0;
    logic [7:0]  cur_en = 8'hD9;
    logic [31:0] slv_val = '0;
    logic [7:0]  ext_b [1:3];

    always @(posedge spi_sck or negedge spi_sck or posedge spi_cs_n) begin
        if (spi_cs_n) begin
            bc = 0;
        end else if (spi_sck) begin
            sh = {sh[6:0], spi_mosi};
            bc++;
            if (bc == 8) begin
                bc = 0;
                if (slog_n < 256) slog[slog_n] = {spi_dc, sh};
                slog_n++;
                if (!spi_dc) begin
                    if (sh == cur_en) begin
                        en_seen = 1'b1;
                        resp = '0;
                    end else if (ext_p != 2'd0) begin
                        resp = {ext_b[ext_p], 32'h0};
                        ext_p = 2'd0;
                    end else begin
                        resp = {1'b1, slv_val, 7'h55};
                    end
                end else if (en_seen) begin
                    ext_p = sh[1:0];
                    en_seen = 1'b0;
                end
            end
        end else begin
            spi_miso = resp[39];
            resp = {resp[38:0], 1'b0};
        end
    end

    task automatic check(input logic ok, input string tag,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    // One access; inject_at>0 pulses a second request while busy.
    task automatic run(input logic ext, input logic [7:0] addr, input logic [7:0] en,
                       input logic [31:0] exp_res, input int inject_at);
        int base, cyc, cshi, nsteps, lat;
        logic [8:0] exp_e;
        base   = slog_n;
        nsteps = ext ? 12 : 6;
        lat    = nsteps * BYTE_CYC + CS_PULSE + 1; // accept edge counted as 1
        cyc = 0;
        cshi = 0;
        @(negedge clk);
        req_valid  = 1'b1;
        req_ext    = ext;
        req_addr   = addr;
        cfg_unlock = en;
        forever begin
            @(posedge clk);
            cyc++;
            @(negedge clk);
            if (cyc == 1) begin
                req_valid = 1'b0;
                check(busy == 1'b1, "R11 busy after accept", 64'(busy), 64'd1);
            end
            if (inject_at > 0 && cyc == inject_at) begin
                req_valid = 1'b1;
                req_addr  = addr ^ 8'h3C;
                req_ext   = ~ext;
            end
            if (inject_at > 0 && cyc == inject_at + 1) req_valid = 1'b0;
            if (spi_cs_n) cshi++;
            if (done) break;
            if (cyc > 3000) break;
        end
        check(done == 1'b1, "R10 done seen", 64'(done), 64'd1);
        check(cyc == lat, "R10 latency", 64'(cyc), 64'(lat));
        check(busy == 1'b0, "R6 busy falls with done", 64'(busy), 64'd0);
        check(spi_cs_n == 1'b0, "R5 cs low at done", 64'(spi_cs_n), 64'd0);
        check(cshi == CS_PULSE, "R5 cs high width", 64'(cshi), 64'(CS_PULSE));
        check(result == exp_res, ext ? "R8 extended result" : "R4 realigned result",
              64'(result), 64'(exp_res));
        check(slog_n - base == nsteps, "R3 byte count", 64'(slog_n - base), 64'(nsteps));
        for (int k = 0; k < nsteps; k++) begin
            if (!ext) begin
                exp_e = (k == 0) ? {1'b0, addr} : 9'h100;
            end else begin
                case (k % 4)
                    0: exp_e = {1'b0, en};
                    1: exp_e = {1'b1, 4'hF, 4'(k / 4 + 1)};
                    2: exp_e = {1'b0, addr};
                    default: exp_e = 9'h100;
                endcase
            end
            check(slog[base + k] == exp_e, ext ? "R8 R9 byte sequence" : "R2 R3 byte sequence",
                  64'(slog[base + k]), 64'(exp_e));
        end
        @(negedge clk);
        check(done == 1'b0, "R6 done one cycle", 64'(done), 64'd0);
        if (inject_at > 0) begin
            repeat (4) @(negedge clk);
            check(busy == 1'b0, "R7 ignored request started nothing", 64'(busy), 64'd0);
            check(slog_n - base == nsteps, "R7 no extra bytes", 64'(slog_n - base), 64'(nsteps));
        end
        check(result == exp_res, "R6 result held", 64'(result), 64'(exp_res));
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        logic [7:0]  en;
        ext_b[1] = '0; ext_b[2] = '0; ext_b[3] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(spi_cs_n == 1'b1 && spi_sck == 1'b0 && spi_mosi == 1'b0 && spi_dc == 1'b1,
              "R1 bus reset", {60'd0, spi_cs_n, spi_sck, spi_mosi, spi_dc}, 64'h9);
        check(busy == 1'b0 && done == 1'b0 && result == '0, "R1 status reset",
              {30'd0, busy, done, result}, 64'd0);

        // Normal reads: edge values and scrambled patterns
        for (int i = 0; i < 12; i++) begin
            if (i == 0)      v = 32'h0000_0000;
            else if (i == 1) v = 32'hFFFF_FFFF;
            else             v = (32'h9E37_79B9 * 32'(i)) ^ (32'h1 << i);
            slv_val = v;
            cur_en  = 8'hD9;
            run(1'b0, 8'h0A + 8'(i * 7), 8'hD9, v, (i == 5) ? 40 : 0);
        end

        // Extended reads with both read-enable codes
        for (int i = 0; i < 6; i++) begin
            en = (i % 2 == 0) ? 8'hD9 : 8'hFB;
            cur_en = en;
            ext_b[1] = 8'(8'h11 * 8'(i + 1));
            ext_b[2] = 8'(~(8'h80 >> i));
            ext_b[3] = (i == 0) ? 8'h00 : (i == 1 ? 8'hFF : 8'(8'h35 + 8'(i * 29)));
            run(1'b1, 8'h09 + 8'(i), en, {8'h00, ext_b[1], ext_b[2], ext_b[3]},
                (i == 3) ? 100 : 0);
        end

        finish_run();
    end
endmodule